// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a programmed number of items from one address to another over a simple request/ready memory port. Each item costs one read beat followed by one write beat that carries the data just read. Software sets the engine up through six word-indexed registers: a source address, a destination address, a remaining-item count, a control word, a source-address alias that starts the channel as it loads, and an abort register.

The control word picks the item size (1, 2 or 4 bytes) and whether each address advances. It can confine one of the two addresses to a power-of-two ring. It also selects which of 63 request lines paces the items, with one code reserved for an always-on request. The same word names a channel to kick when this one finishes and can mute the completion interrupt. Two further bits only pass through to the outside: high priority and sniffer watch.

A start comes from three places: a control write with the enable bit set, a write to the start alias, or a chain pulse from another channel. Completion clears busy and pulses the interrupt and chain outputs for one cycle. An abort returns the channel to idle at once.

Top module: `dma_chan_top`

## Requirements
- R1: After reset every register reads 0, busy (control readback bit 24) is 0, and memReq, irqOut and chainOut are low.
- R2: Register index 0 holds the source address, 1 the destination address, 2 the count and 3 the control word, which reads back as written except that bit 24 shows busy. Index 4 reads the source address and index 5 reads 0.
- R3: A control write with bit 0 set starts the channel when it is idle and the count is nonzero. If the count is zero, nothing starts.
- R4: Each item is one read at the source address, then one write to the destination address carrying the read data. memReq, memAddr and memWe hold steady until memReady is seen.
- R5: Control bits 3:2 give the item size as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The size appears on memSize, and an advancing address steps by that many bytes per item.
- R6: Control bit 4 lets the source address advance and bit 5 lets the destination advance. When the bit is clear, that address stays fixed for the whole transfer.
- R7: Control bits 9:6 give a ring size n. If n is nonzero, the address chosen by bit 10 (0 = source, 1 = destination) keeps the bits above bit n-1 fixed and wraps its low n bits.
- R8: Control bits 20:15 pick the pacing source. Code 63 always allows a transfer. Any other code c lets an item start only while reqLines[c] is high.
- R9: When the last item's write is accepted, the count reads 0 and busy drops. irqOut pulses for exactly one cycle in that same cycle unless control bit 21 is set.
- R10: At completion, chainOut pulses for one cycle with chainTarget equal to control bits 14:11, unless that field equals the channel's own number. A chainIn pulse starts an enabled, idle channel that has a nonzero count.
- R11: Writing index 4 loads the source address and, if control bit 0 is already set, starts the channel in the same write.
- R12: Writing index 5 with the channel's own bit set stops the channel with no completion pulses. Writes with only other bits set have no effect.
- R13: highPri follows control bit 1 and sniffWatch follows control bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| reqLines | input | 63 | Pacing request lines |
| chainIn | input | 1 | Start pulse from another channel |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memSize | output | 2 | Item size code |
| memAddr | output | ADDR_W | Beat address |
| memWdata | output | 32 | Write beat data |
| memRdata | input | 32 | Read beat data |
| memReady | input | 1 | Beat accepted this cycle |
| irqOut | output | 1 | Completion interrupt pulse |
| chainOut | output | 1 | Chain trigger pulse |
| chainTarget | output | 4 | Channel number to trigger |
| highPri | output | 1 | High-priority flag |
| sniffWatch | output | 1 | Sniffer watch flag |

## Verification
On every cycle, the assertions check a set of invariants. A request only appears while busy, and an unaccepted beat holds its address and direction. Each accepted write lowers the count by exactly one. A ring-wrapped destination keeps its upper bits. A read only begins after the selected request line allowed it. Completion pulses appear only with busy low, never while muted, and never aimed at the channel itself. The bench scenarios cover what needs a whole transfer to show: the exact address sequence for each size, for fixed addresses and for wraps in both rings. They also cover start from each of the three sources, refusal to start on a zero count, held-off pacing, and an abort that leaves the count untouched and raises no interrupt.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  localparam int REG_W   = 32;
  localparam int REQ_W   = 6;
  localparam int NUM_REQ = (1 << REQ_W) - 1;
  localparam int SEL_W   = 4;
  localparam int RING_W  = 4;

  localparam logic [2:0] IDX_SRC   = 3'd0;
  localparam logic [2:0] IDX_DST   = 3'd1;
  localparam logic [2:0] IDX_CNT   = 3'd2;
  localparam logic [2:0] IDX_CTRL  = 3'd3;
  localparam logic [2:0] IDX_GO    = 3'd4;
  localparam logic [2:0] IDX_ABORT = 3'd5;

  localparam int CB_EN      = 0;
  localparam int CB_HIPRI   = 1;
  localparam int CB_SIZE    = 2;
  localparam int CB_SRCINC  = 4;
  localparam int CB_DSTINC  = 5;
  localparam int CB_RING    = 6;
  localparam int CB_RINGDST = 10;
  localparam int CB_CHAIN   = 11;
  localparam int CB_REQ     = 15;
  localparam int CB_QUIET   = 21;
  localparam int CB_WATCH   = 23;
  localparam int CB_BUSY    = 24;

  typedef struct packed {
    logic rdBeat;
    logic wrBeat;
  } chanStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_READ, ST_WRITE} chanState_t;
endpackage

// File: rtl/dma_chan_dp.sv
`timescale 1ns/1ps
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              busy,
  input  chanStrobe_t       strobe,
  input  logic [REG_W-1:0]  memRdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic [REG_W-1:0]  dataReg,
  output logic              enable,
  output logic              highPri,
  output logic              quiet,
  output logic              watch,
  output logic [1:0]        sizeCode,
  output logic [SEL_W-1:0]  chainSel,
  output logic [REQ_W-1:0]  reqSel,
  output logic [RING_W-1:0] ringSize,
  output logic              ringOnDst
);
  logic [REG_W-1:0]  ctrlWord;
  logic [ADDR_W-1:0] srcNext, dstNext;

  function automatic logic [ADDR_W-1:0] stepAddr(
    input logic [ADDR_W-1:0] a,
    input logic [1:0]        sz,
    input logic [RING_W-1:0] ring,
    input logic              wrapHere
  );
    logic [ADDR_W-1:0] stepV, sum, mask;
    stepV = (sz == 2'd0) ? ADDR_W'(1) : (sz == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
    sum   = a + stepV;
    mask  = (ADDR_W'(1) << ring) - ADDR_W'(1);
    if (wrapHere && ring != '0) return (a & ~mask) | (sum & mask);
    return sum;
  endfunction

  assign enable    = ctrlWord[CB_EN];
  assign highPri   = ctrlWord[CB_HIPRI];
  assign quiet     = ctrlWord[CB_QUIET];
  assign watch     = ctrlWord[CB_WATCH];
  assign sizeCode  = ctrlWord[CB_SIZE +: 2];
  assign chainSel  = ctrlWord[CB_CHAIN +: SEL_W];
  assign reqSel    = ctrlWord[CB_REQ +: REQ_W];
  assign ringSize  = ctrlWord[CB_RING +: RING_W];
  assign ringOnDst = ctrlWord[CB_RINGDST];

  assign srcNext = ctrlWord[CB_SRCINC] ? stepAddr(srcAddr, sizeCode, ringSize, !ringOnDst) : srcAddr;
  assign dstNext = ctrlWord[CB_DSTINC] ? stepAddr(dstAddr, sizeCode, ringSize, ringOnDst) : dstAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      count    <= '0;
      ctrlWord <= '0;
      dataReg  <= '0;
    end else begin
      if (regWe && (regAddr == IDX_SRC || regAddr == IDX_GO)) srcAddr <= regWdata[ADDR_W-1:0];
      else if (strobe.rdBeat) srcAddr <= srcNext;

      if (regWe && regAddr == IDX_DST) dstAddr <= regWdata[ADDR_W-1:0];
      else if (strobe.wrBeat) dstAddr <= dstNext;

      if (regWe && regAddr == IDX_CNT) count <= regWdata[CNT_W-1:0];
      else if (strobe.wrBeat) count <= count - CNT_W'(1);

      if (regWe && regAddr == IDX_CTRL) ctrlWord <= regWdata & ~(REG_W'(1) << CB_BUSY);

      if (strobe.rdBeat) dataReg <= memRdata;
    end
  end

  always_comb begin
    case (regAddr)
      IDX_SRC, IDX_GO: regRdata = REG_W'(srcAddr);
      IDX_DST:         regRdata = REG_W'(dstAddr);
      IDX_CNT:         regRdata = REG_W'(count);
      IDX_CTRL:        regRdata = ctrlWord | (REG_W'(busy) << CB_BUSY);
      default:         regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int CHAN_ID = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic               wrEnBit,
  input  logic               wrAbortBit,
  input  logic               enable,
  input  logic               quiet,
  input  logic [SEL_W-1:0]   chainSel,
  input  logic [REQ_W-1:0]   reqSel,
  input  logic [CNT_W-1:0]   count,
  input  logic [NUM_REQ-1:0] reqLines,
  input  logic               chainIn,
  input  logic               memReady,
  output logic               busy,
  output chanStrobe_t        strobe,
  output logic               memReq,
  output logic               memWe,
  output logic               irqOut,
  output logic               chainOut
);
  chanState_t       state, nextState;
  logic [NUM_REQ:0] gateVec;
  logic             reqOk, wantStart, abortHit, done;

  assign gateVec   = {1'b1, reqLines};
  assign reqOk     = gateVec[reqSel];
  assign wantStart = (regWe && regAddr == IDX_CTRL && wrEnBit) ||
                     (enable && ((regWe && regAddr == IDX_GO) || chainIn));
  assign abortHit  = regWe && regAddr == IDX_ABORT && wrAbortBit;

  always_comb begin
    nextState = state;
    strobe    = '0;
    done      = 1'b0;
    case (state)
      ST_IDLE:  if (wantStart && count != '0) nextState = ST_ARM;
      ST_ARM:   if (reqOk) nextState = ST_READ;
      ST_READ:  if (memReady) begin
                  strobe.rdBeat = 1'b1;
                  nextState     = ST_WRITE;
                end
      ST_WRITE: if (memReady) begin
                  strobe.wrBeat = 1'b1;
                  if (count == CNT_W'(1)) begin
                    done      = 1'b1;
                    nextState = ST_IDLE;
                  end else begin
                    nextState = ST_ARM;
                  end
                end
      default:  nextState = ST_IDLE;
    endcase
    if (abortHit) begin
      nextState = ST_IDLE;
      done      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irqOut   <= 1'b0;
      chainOut <= 1'b0;
    end else begin
      state    <= nextState;
      irqOut   <= done && !quiet;
      chainOut <= done && (chainSel != SEL_W'(CHAN_ID));
    end
  end

  assign busy   = state != ST_IDLE;
  assign memReq = state == ST_READ || state == ST_WRITE;
  assign memWe  = state == ST_WRITE;
endmodule

// File: rtl/dma_chan_top.sv
`timescale 1ns/1ps
module dma_chan_top
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  parameter int CHAN_ID = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic [NUM_REQ-1:0] reqLines,
  input  logic               chainIn,
  output logic               memReq,
  output logic               memWe,
  output logic [1:0]         memSize,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [REG_W-1:0]   memWdata,
  input  logic [REG_W-1:0]   memRdata,
  input  logic               memReady,
  output logic               irqOut,
  output logic               chainOut,
  output logic [SEL_W-1:0]   chainTarget,
  output logic               highPri,
  output logic               sniffWatch
);
  chanStrobe_t       strobe;
  logic              busy, enable, quiet, ringOnDst;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [CNT_W-1:0]  count;
  logic [REG_W-1:0]  dataReg;
  logic [REQ_W-1:0]  reqSel;
  logic [RING_W-1:0] ringSize;

  dma_chan_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .busy(busy), .strobe(strobe), .memRdata(memRdata), .regRdata(regRdata),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .count(count), .dataReg(dataReg),
    .enable(enable), .highPri(highPri), .quiet(quiet), .watch(sniffWatch),
    .sizeCode(memSize), .chainSel(chainTarget), .reqSel(reqSel),
    .ringSize(ringSize), .ringOnDst(ringOnDst)
  );

  dma_chan_ctrl #(.CNT_W(CNT_W), .CHAN_ID(CHAN_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .wrEnBit(regWdata[CB_EN]), .wrAbortBit(regWdata[CHAN_ID]),
    .enable(enable), .quiet(quiet), .chainSel(chainTarget), .reqSel(reqSel),
    .count(count), .reqLines(reqLines), .chainIn(chainIn), .memReady(memReady),
    .busy(busy), .strobe(strobe), .memReq(memReq), .memWe(memWe),
    .irqOut(irqOut), .chainOut(chainOut)
  );

  assign memAddr  = memWe ? dstAddr : srcAddr;
  assign memWdata = dataReg;
endmodule

// File: rtl/dma_chan_chk.sv
`timescale 1ns/1ps
module dma_chan_chk
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  parameter int CHAN_ID = 0
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWe,
  input logic               memReq,
  input logic               memWe,
  input logic               memReady,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               busy,
  input logic               irqOut,
  input logic               chainOut,
  input logic [SEL_W-1:0]   chainTarget,
  input logic               quiet,
  input logic [CNT_W-1:0]   count,
  input logic [ADDR_W-1:0]  dstAddr,
  input logic [RING_W-1:0]  ringSize,
  input logic               ringOnDst,
  input logic [NUM_REQ-1:0] reqLines,
  input logic [REQ_W-1:0]   reqSel
);
  logic [NUM_REQ:0] gateVec;
  logic             gateOk;
  assign gateVec = {1'b1, reqLines};
  assign gateOk  = gateVec[reqSel];

  // R4
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady && !regWe |=> memReq && $stable(memAddr) && $stable(memWe));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || chainOut) |-> !busy);

  // R9
  quiet_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !$past(regWe) |-> !quiet);

  // R10
  chain_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainOut && !$past(regWe) |-> chainTarget != SEL_W'(CHAN_ID));

  // R9
  count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady && !regWe |=> count == $past(count) - CNT_W'(1));

  // R7
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady && !regWe && ringOnDst && ringSize != '0
    |=> (dstAddr >> ringSize) == ($past(dstAddr) >> ringSize));

  // R8
  pace_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(gateOk));
endmodule

bind dma_chan_top dma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CHAN_ID(CHAN_ID)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .memReq(memReq), .memWe(memWe),
  .memReady(memReady), .memAddr(memAddr), .busy(busy), .irqOut(irqOut),
  .chainOut(chainOut), .chainTarget(chainTarget), .quiet(quiet), .count(count),
  .dstAddr(dstAddr), .ringSize(ringSize), .ringOnDst(ringOnDst),
  .reqLines(reqLines), .reqSel(reqSel)
);

// File: tb/sim_dma_chan_top.sv
`timescale 1ns/1ps
module sim_dma_chan_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd3;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [62:0] reqLines = '0;
  logic        chainIn = 1'b0;
  logic        memReq, memWe, memReady;
  logic [1:0]  memSize;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        irqOut, chainOut, highPri, sniffWatch;
  logic [3:0]  chainTarget;

  int tests = 0;
  int failed = 0;
  int irqCnt = 0;
  int chainCnt = 0;
  logic [3:0] lastTarget = '0;
  logic [7:0] lfsr = 8'h5b;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    string       tag;
  } op_t;
  op_t expQ[$];

  always #10 clk = ~clk;

  assign memRdata = memAddr ^ 32'h5A5A_0000;

  dma_chan_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .reqLines(reqLines), .chainIn(chainIn), .memReq(memReq),
    .memWe(memWe), .memSize(memSize), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .irqOut(irqOut), .chainOut(chainOut),
    .chainTarget(chainTarget), .highPri(highPri), .sniffWatch(sniffWatch)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCtrl(input int en, input int size, input int srcInc,
      input int dstInc, input int ring, input int ringDst, input int chain, input int req,
      input int quietB, input int hiPri, input int watchB);
    return 32'(en) | (32'(hiPri) << 1) | (32'(size) << 2) | (32'(srcInc) << 4) |
           (32'(dstInc) << 5) | (32'(ring) << 6) | (32'(ringDst) << 10) |
           (32'(chain) << 11) | (32'(req) << 15) | (32'(quietB) << 21) | (32'(watchB) << 23);
  endfunction

  function automatic logic [31:0] nextA(input logic [31:0] a, input int size, input int inc,
      input int ring, input int wrapHere);
    logic [31:0] step, m;
    if (inc == 0) return a;
    step = 32'd1 << size;
    if (wrapHere != 0 && ring != 0) begin
      m = (32'd1 << ring) - 32'd1;
      return (a & ~m) | ((a + step) & m);
    end
    return a + step;
  endfunction

  task automatic pushItems(input logic [31:0] src, input logic [31:0] dst, input int n,
      input int size, input int srcInc, input int dstInc, input int ring, input int ringDst,
      input string tag);
    logic [31:0] s, d;
    op_t o;
    s = src;
    d = dst;
    for (int i = 0; i < n; i++) begin
      o.we = 1'b0; o.addr = s; o.data = '0; o.size = 2'(size); o.tag = tag;
      expQ.push_back(o);
      o.we = 1'b1; o.addr = d; o.data = s ^ 32'h5A5A_0000;
      expQ.push_back(o);
      s = nextA(s, size, srcInc, ring, ringDst == 0 ? 1 : 0);
      d = nextA(d, size, dstInc, ring, ringDst);
    end
  endtask

  task automatic writeReg(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regAddr = idx; regWdata = data;
    @(negedge clk);
    regWe = 1'b0; regAddr = 3'd3;
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    regAddr = idx;
    #1 val = regRdata;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regAddr = 3'd3;
      #1;
      if (!regRdata[24]) break;
    end
  endtask

  // memory acceptance pattern
  initial begin
    memReady = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      memReady = lfsr[0] | lfsr[2];
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (irqOut) irqCnt++;
      if (chainOut) begin
        chainCnt++;
        lastTarget = chainTarget;
      end
      if (rstN && memReq && memReady) begin
        if (expQ.size() == 0) begin
          checkEq("R4 unexpected beat", memAddr, 32'hFFFF_FFFF);
        end else begin
          op_t o;
          o = expQ.pop_front();
          checkEq({o.tag, " direction"}, 32'(memWe), 32'(o.we));
          checkEq({o.tag, " address"}, memAddr, o.addr);
          checkEq({o.tag, " size R5"}, 32'(memSize), 32'(o.size));
          if (o.we) checkEq({o.tag, " data R4"}, memWdata, o.data);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failed++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int irq0, ch0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      readReg(3'(i), v);
      checkEq("R1 register reset", v, 32'h0);
    end
    checkEq("R1 memReq reset", 32'(memReq), 0);
    checkEq("R1 pulses reset", 32'(irqOut | chainOut), 0);

    // R2 register map
    writeReg(3'd0, 32'h0000_1000);
    writeReg(3'd1, 32'h0000_3000);
    writeReg(3'd2, 32'd0);
    readReg(3'd0, v); checkEq("R2 source readback", v, 32'h1000);
    readReg(3'd1, v); checkEq("R2 destination readback", v, 32'h3000);
    readReg(3'd4, v); checkEq("R2 alias readback", v, 32'h1000);
    readReg(3'd5, v); checkEq("R2 abort readback", v, 32'h0);

    // R3 zero count does not start
    writeReg(3'd3, mkCtrl(1, 2, 1, 1, 0, 0, 0, 63, 0, 0, 0));
    repeat (4) @(negedge clk);
    readReg(3'd3, v);
    checkEq("R3 zero count stays idle", 32'(v[24]), 0);
    checkEq("R3 zero count no request", 32'(memReq), 0);

    // R4 R5 R9 word transfer, both advancing
    writeReg(3'd2, 32'd4);
    pushItems(32'h1000, 32'h3000, 4, 2, 1, 1, 0, 0, "R4 word");
    irq0 = irqCnt; ch0 = chainCnt;
    writeReg(3'd3, mkCtrl(1, 2, 1, 1, 0, 0, 0, 63, 0, 0, 0));
    readReg(3'd3, v);
    checkEq("R3 start sets busy", 32'(v[24]), 1);
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R4 scoreboard drained", 32'(expQ.size()), 0);
    checkEq("R9 one interrupt", 32'(irqCnt - irq0), 1);
    checkEq("R10 self chain silent", 32'(chainCnt - ch0), 0);
    readReg(3'd2, v); checkEq("R9 count zero", v, 0);
    readReg(3'd1, v); checkEq("R5 destination stepped by 4", v, 32'h3010);

    // R5 R6 byte size, fixed destination
    writeReg(3'd0, 32'h0000_2001);
    writeReg(3'd1, 32'h0000_8000);
    writeReg(3'd2, 32'd3);
    pushItems(32'h2001, 32'h8000, 3, 0, 1, 0, 0, 0, "R6 fixed dst");
    writeReg(3'd3, mkCtrl(1, 0, 1, 0, 0, 0, 0, 63, 0, 0, 0));
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R6 scoreboard drained", 32'(expQ.size()), 0);
    readReg(3'd1, v); checkEq("R6 destination unchanged", v, 32'h8000);

    // R7 halfword, ring of 8 bytes on source
    writeReg(3'd0, 32'h0000_1004);
    writeReg(3'd1, 32'h0000_5000);
    writeReg(3'd2, 32'd5);
    pushItems(32'h1004, 32'h5000, 5, 1, 1, 1, 3, 0, "R7 source ring");
    writeReg(3'd3, mkCtrl(1, 1, 1, 1, 3, 0, 0, 63, 0, 0, 0));
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R7 source ring drained", 32'(expQ.size()), 0);
    readReg(3'd0, v); checkEq("R7 source wrapped", v, 32'h1006);

    // R7 word, ring of 16 bytes on destination
    writeReg(3'd0, 32'h0000_6000);
    writeReg(3'd1, 32'h0000_200C);
    writeReg(3'd2, 32'd3);
    pushItems(32'h6000, 32'h200C, 3, 2, 1, 1, 4, 1, "R7 dest ring");
    writeReg(3'd3, mkCtrl(1, 2, 1, 1, 4, 1, 0, 63, 0, 0, 0));
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R7 dest ring drained", 32'(expQ.size()), 0);
    readReg(3'd1, v); checkEq("R7 destination wrapped", v, 32'h2008);

    // R8 paced on line 5
    writeReg(3'd0, 32'h0000_7000);
    writeReg(3'd1, 32'h0000_7100);
    writeReg(3'd2, 32'd2);
    pushItems(32'h7000, 32'h7100, 2, 2, 1, 1, 0, 0, "R8 paced");
    writeReg(3'd3, mkCtrl(1, 2, 1, 1, 0, 0, 0, 5, 0, 0, 0));
    repeat (20) @(negedge clk);
    checkEq("R8 held without request", 32'(memReq), 0);
    checkEq("R8 nothing consumed", 32'(expQ.size()), 4);
    reqLines[5] = 1'b1;
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R8 paced drained", 32'(expQ.size()), 0);
    reqLines = '0;

    // R9 R10 quiet completion with chain to 3
    writeReg(3'd0, 32'h0000_9000);
    writeReg(3'd1, 32'h0000_9100);
    writeReg(3'd2, 32'd2);
    pushItems(32'h9000, 32'h9100, 2, 2, 1, 1, 0, 0, "R10 chained");
    irq0 = irqCnt; ch0 = chainCnt;
    writeReg(3'd3, mkCtrl(1, 2, 1, 1, 0, 0, 3, 63, 1, 0, 0));
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R9 quiet no interrupt", 32'(irqCnt - irq0), 0);
    checkEq("R10 chain pulse once", 32'(chainCnt - ch0), 1);
    checkEq("R10 chain target", 32'(lastTarget), 3);

    // R10 chainIn start (count is zero when enabled)
    writeReg(3'd3, mkCtrl(1, 2, 1, 1, 0, 0, 0, 63, 0, 0, 0));
    readReg(3'd3, v);
    checkEq("R3 enable with zero count idle", 32'(v[24]), 0);
    writeReg(3'd0, 32'h0000_A000);
    writeReg(3'd1, 32'h0000_A800);
    writeReg(3'd2, 32'd2);
    readReg(3'd3, v);
    checkEq("R10 count write alone no start", 32'(v[24]), 0);
    pushItems(32'hA000, 32'hA800, 2, 2, 1, 1, 0, 0, "R10 chainIn");
    @(negedge clk); chainIn = 1'b1;
    @(negedge clk); chainIn = 1'b0;
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R10 chainIn drained", 32'(expQ.size()), 0);

    // R11 start alias
    writeReg(3'd1, 32'h0000_C000);
    writeReg(3'd2, 32'd3);
    pushItems(32'h4400, 32'hC000, 3, 2, 1, 1, 0, 0, "R11 alias");
    writeReg(3'd4, 32'h0000_4400);
    waitIdle();
    repeat (2) @(negedge clk);
    checkEq("R11 alias drained", 32'(expQ.size()), 0);
    readReg(3'd4, v); checkEq("R11 R2 alias reads source", v, 32'h440C);

    // R12 abort
    writeReg(3'd2, 32'd100);
    irq0 = irqCnt;
    writeReg(3'd3, mkCtrl(1, 2, 1, 1, 0, 0, 2, 7, 0, 0, 0));
    repeat (5) @(negedge clk);
    writeReg(3'd5, 32'h0000_0002);
    readReg(3'd3, v);
    checkEq("R12 other bit ignored", 32'(v[24]), 1);
    writeReg(3'd5, 32'h0000_0001);
    readReg(3'd3, v);
    checkEq("R12 abort clears busy", 32'(v[24]), 0);
    repeat (3) @(negedge clk);
    checkEq("R12 no interrupt", 32'(irqCnt - irq0), 0);
    readReg(3'd2, v); checkEq("R12 count untouched", v, 32'd100);

    // R13 pass-through flags and R2 control readback
    writeReg(3'd3, mkCtrl(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1));
    checkEq("R13 highPri", 32'(highPri), 1);
    checkEq("R13 sniffWatch", 32'(sniffWatch), 1);
    readReg(3'd3, v);
    checkEq("R2 control readback", v, mkCtrl(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1));

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule